// File: doc/BRIEF.md
# Dual-Path SPI Serial Clock Generator

This block produces the serial clock for an SPI shift engine from the system clock. Two divider algorithms run through one shared down-counter. The exponential path divides the system clock by 4·2^N, where N is a 3-bit exponent. The linear path divides it by 2·(N+1), where N is an 8-bit value. A select input picks which of the two sets the reload value.

Each time the counter reaches its terminal count, the serial clock toggles. This gives a 50% duty clock. In the same cycle as each toggle, the block pulses one of two single-cycle strobes: one when the clock leaves its idle level (the leading edge) and one when it returns to idle (the trailing edge). A shift engine can use these strobes to launch and capture data.

A new divider setting is picked up only at a terminal count, so a half period that has already started always finishes at its original length. While the generator is disabled, the clock rests at the polarity input's level and no strobes are produced.

Top module: `spi_sclk_gen`

## Requirements
- R1: While `rst` is high (synchronous, active high), on each clock edge `sclk` takes the value of `cpol`, and `lead_stb` and `trail_stb` are 0.
- R2: With `sel_lin`=0 and `en`=1, every high phase and every low phase of `sclk` lasts 2^(`pow2_exp`+1) system clock cycles, so `pow2_exp`=0 divides by 4 and `pow2_exp`=3 divides by 32.
- R3: With `sel_lin`=1 and `en`=1, every phase of `sclk` lasts `lin_div`+1 cycles, so the clock period is 2·(`lin_div`+1) cycles.
- R4: The high phase and the low phase of `sclk` have equal length (50% duty).
- R5: Each change of `sclk` while enabled comes with exactly one single-cycle strobe in the same cycle. `lead_stb`=1 when the new level differs from `cpol`, and `trail_stb`=1 when the new level equals `cpol`. Neither strobe is 1 in any other cycle.
- R6: One clock edge after `en` is sampled low, `sclk` equals `cpol`, and it stays there with no strobes for as long as `en` stays low.
- R7: A change to `sel_lin`, `pow2_exp` or `lin_div` while enabled does not shorten or lengthen the phase in progress. The new length applies from the next phase.
- R8: After `en` rises, the first `sclk` change comes one full phase length later, counting the first cycle with `en` high as cycle 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Divider run enable |
| cpol | input | 1 | Idle level of the serial clock |
| sel_lin | input | 1 | 1 selects the linear path, 0 the exponential path |
| pow2_exp | input | 3 | Exponent N of the exponential path |
| lin_div | input | 8 | Value N of the linear path |
| sclk | output | 1 | Serial clock, registered |
| lead_stb | output | 1 | Pulse on the edge leaving the idle level |
| trail_stb | output | 1 | Pulse on the edge returning to the idle level |

## Verification
The bench sweeps every exponent and a dense range of linear values, including 0 and 255, under both polarities. It measures every phase arithmetically, so a divider that is off by one or that uses the wrong path would show as a wrong phase count, and an uneven duty cycle would show as a mismatch between the high and low phases. It changes the divider value and the path select in the middle of a phase and expects the old length to finish first; a design that reloads at once would produce a short pulse. It also disables the generator partway through a phase, which catches a design that leaves the clock at the wrong level or keeps emitting strobes. At every change of `sclk` it checks that the strobe matches the direction of the edge, which catches swapped or missing strobes.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;
  localparam int EXP_W = 3;
  localparam int LIN_W = 8;
  // counter must hold the longer half period of either path
  localparam int CNT_W = ((2 ** EXP_W) > LIN_W) ? (2 ** EXP_W) : LIN_W;

  typedef struct packed {
    logic             sel_lin;
    logic [EXP_W-1:0] pow2_exp;
    logic [LIN_W-1:0] lin_div;
  } div_cfg_t;
endpackage

// File: rtl/spi_sclk_reload.sv
module spi_sclk_reload
  import spi_sclk_pkg::*;
(
  input  div_cfg_t         cfg,
  output logic [CNT_W-1:0] reload
);
  logic [EXP_W:0]   shamt;
  logic [CNT_W-1:0] pow_half;

  // half period of the exponential path is 2^(N+1); a shift past the
  // top bit yields zero and the decrement wraps to all ones
  always_comb begin
    shamt    = {1'b0, cfg.pow2_exp} + {{EXP_W{1'b0}}, 1'b1};
    pow_half = CNT_W'(1) << shamt;
    if (cfg.sel_lin)
      reload = CNT_W'(cfg.lin_div);
    else
      reload = pow_half - CNT_W'(1);
  end
endmodule

// File: rtl/spi_sclk_count.sv
module spi_sclk_count
  import spi_sclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] reload,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;

  assign tick = en && (cnt == '0);

  // reload is sampled only while idle or at terminal count
  always_ff @(posedge clk) begin
    if (rst || !en)
      cnt <= reload;
    else if (cnt == '0)
      cnt <= reload;
    else
      cnt <= cnt - CNT_W'(1);
  end
endmodule

// File: rtl/spi_sclk_edge.sv
module spi_sclk_edge (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic cpol,
  input  logic tick,
  output logic sclk,
  output logic lead_stb,
  output logic trail_stb
);
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sclk      <= cpol;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else begin
      lead_stb  <= tick && (sclk == cpol);
      trail_stb <= tick && (sclk != cpol);
      if (tick)
        sclk <= ~sclk;
    end
  end
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import spi_sclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             cpol,
  input  logic             sel_lin,
  input  logic [EXP_W-1:0] pow2_exp,
  input  logic [LIN_W-1:0] lin_div,
  output logic             sclk,
  output logic             lead_stb,
  output logic             trail_stb
);
  div_cfg_t         cfg;
  logic [CNT_W-1:0] reload;
  logic             tick;

  assign cfg = '{sel_lin: sel_lin, pow2_exp: pow2_exp, lin_div: lin_div};

  spi_sclk_reload u_reload (.cfg(cfg), .reload(reload));

  spi_sclk_count u_count (
    .clk(clk), .rst(rst), .en(en), .reload(reload), .tick(tick)
  );

  spi_sclk_edge u_edge (
    .clk(clk), .rst(rst), .en(en), .cpol(cpol), .tick(tick),
    .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
  );
endmodule

// File: rtl/spi_sclk_gen_chk.sv
module spi_sclk_gen_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic cpol,
  input logic sclk,
  input logic lead_stb,
  input logic trail_stb
);
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !en |=> (sclk == $past(cpol))); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!lead_stb && !trail_stb)); // R6

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(lead_stb && trail_stb)); // R5

  AST_STB_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && (sclk != $past(sclk))) |-> (lead_stb || trail_stb)); // R5

  AST_STB_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    (lead_stb || trail_stb) |-> (sclk != $past(sclk))); // R5
endmodule

bind spi_sclk_gen spi_sclk_gen_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .cpol(cpol),
  .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
);

// File: tb/tb_spi_sclk_gen.sv
module tb_spi_sclk_gen;
  logic       clk = 1'b0;
  logic       rst, en, cpol, sel_lin;
  logic [2:0] pow2_exp;
  logic [7:0] lin_div;
  logic       sclk, lead_stb, trail_stb;
  int         total = 0;
  int         bad = 0;

  always #2 clk = ~clk; // 250 MHz

  spi_sclk_gen dut (
    .clk(clk), .rst(rst), .en(en), .cpol(cpol), .sel_lin(sel_lin),
    .pow2_exp(pow2_exp), .lin_div(lin_div),
    .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  // counts cycles until sclk changes; checks strobes on the way (R5)
  task automatic measure(output int n);
    logic prev = sclk;
    int   stray = 0;
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (sclk != prev) break;
      if (lead_stb || trail_stb) stray++;
      if (n > 700) break;
    end
    check(stray == 0, "R5 no strobe between edges", stray, 0);
    check(lead_stb == (sclk != cpol) && trail_stb == (sclk == cpol),
          "R5 strobe direction", {30'd0, lead_stb, trail_stb},
          (sclk != cpol) ? 2 : 1);
  endtask

  task automatic run_cfg(input bit lin, input int val, input bit cp);
    int h, hi_len, lo_len, expd;
    en = 1'b0; cpol = cp; sel_lin = lin;
    if (lin) lin_div = 8'(val); else pow2_exp = 3'(val);
    expd = lin ? val + 1 : (1 << (val + 1));
    @(negedge clk); @(negedge clk);
    check(sclk == cp && !lead_stb && !trail_stb, "R6 idle level", sclk, cp);
    en = 1'b1;
    measure(h);
    check(h == expd, "R8 first edge delay", h, expd);
    for (int k = 0; k < 4; k++) begin
      measure(h);
      check(h == expd, lin ? "R3 linear phase" : "R2 pow2 phase", h, expd);
      if (k == 2) hi_len = h;
      if (k == 3) lo_len = h;
    end
    check(hi_len == lo_len, "R4 duty", hi_len, lo_len);
  endtask

  initial begin
    int h, quiet;
    rst = 1'b1; en = 1'b0; cpol = 1'b0; sel_lin = 1'b0;
    pow2_exp = 3'd0; lin_div = 8'd0;
    repeat (3) @(negedge clk);
    check(sclk == 1'b0 && !lead_stb && !trail_stb, "R1 reset state", sclk, 0);
    cpol = 1'b1;
    @(negedge clk);
    check(sclk == 1'b1, "R1 reset follows cpol", sclk, 1);
    rst = 1'b0;

    for (int e = 0; e < 8; e++)
      for (int cp = 0; cp < 2; cp++) run_cfg(1'b0, e, 1'(cp));
    for (int v = 0; v < 41; v++) run_cfg(1'b1, v, 1'(v % 2));
    run_cfg(1'b1, 100, 1'b0);
    run_cfg(1'b1, 200, 1'b1);
    run_cfg(1'b1, 255, 1'b0);

    // R7: change lin_div mid-phase
    en = 1'b0; cpol = 1'b0; sel_lin = 1'b1; lin_div = 8'd9;
    @(negedge clk); @(negedge clk);
    en = 1'b1;
    measure(h);
    repeat (3) @(negedge clk);
    lin_div = 8'd3;
    measure(h);
    check(h == 7, "R7 phase in progress kept", h, 7);
    measure(h);
    check(h == 4, "R7 new length next phase", h, 4);
    // R7: switch path mid-phase
    @(negedge clk);
    sel_lin = 1'b0; pow2_exp = 3'd2;
    measure(h);
    check(h == 3, "R7 path switch keeps phase", h, 3);
    measure(h);
    check(h == 8, "R7 pow2 after switch", h, 8);

    // R6: disable in mid-phase with cpol=1
    en = 1'b0; cpol = 1'b1; sel_lin = 1'b1; lin_div = 8'd5;
    @(negedge clk); @(negedge clk);
    en = 1'b1;
    measure(h);
    repeat (2) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(sclk == 1'b1, "R6 returns to idle", sclk, 1);
    quiet = 0;
    repeat (20) begin
      @(negedge clk);
      if (sclk != 1'b1 || lead_stb || trail_stb) quiet++;
    end
    check(quiet == 0, "R6 stays idle", quiet, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule